// File: doc/BRIEF.md
# Shadow Readback Sequencer for Write-Only Legacy Registers

This block lets software read back legacy peripheral registers that the bus normally treats as write-only: DMA command, request, mode and mask settings, timer count-register bytes, and interrupt-controller initialization and operation words. The peripheral cores report each such write on a capture bus. The block keeps its own copy of every captured value in a small register file. A configuration byte holds a shadow-enable bit. While that bit is clear, ports behave in the usual way. While it is set, repeated reads of a few I/O ports walk through the stored copies in a fixed order.

The block also steers DMA address and count traffic between the base and current registers of the DMA core. In normal mode, reads return the current value and writes load the base value. Shadow mode swaps both. Each walking port has its own position index. The index moves forward only when a read finishes. It returns to the first entry on reset, on a write to that port, and whenever shadow mode is off.

Top module: `shadow_readback`

## Requirements
- R1: The configuration byte reads 02h after reset. Bit 0 is the shadow enable. A write stores the byte, except that bit 7 always reads back as 0.
- R2: In shadow mode, successive reads of port 08h return copy ids 0 to 5 (command, request, mode of channels 0 to 3) and then wrap to id 0. Port D0h does the same over ids 6 to 11.
- R3: In shadow mode, successive reads of port 40h return copy ids 14 to 20 (counter 0 status, then low and high count bytes of counters 0, 1 and 2) and then wrap to id 14. In normal mode, a read of 40h is claimed and returns 00h.
- R4: In shadow mode, successive reads of port 20h return copy ids 21 to 34 and then wrap to id 21. Ids 21 to 27 hold the first controller's four initialization words and three operation words; ids 28 to 34 hold the same for the second controller.
- R5: An index advances one step in the cycle after its port's read strobe falls. A read held for several cycles returns the same value throughout. Reads of other ports leave the index unchanged.
- R6: An index returns to its first entry on a write to its own port, and while shadow mode is disabled.
- R7: A read of a DMA address or count port (00h to 07h, or an even address from C0h to CEh) is claimed. It returns `dma_cur_rdata` in normal mode and `dma_base_rdata` in shadow mode.
- R8: A write to a DMA address or count port raises `dma_base_we` in normal mode or `dma_cur_we` in shadow mode, never both. A write to any other address raises neither.
- R9: In shadow mode, a read of port 0Fh returns the low nibble of copy id 12, and a read of DEh returns the low nibble of copy id 13, with the upper nibble 0. In normal mode, neither port is claimed.
- R10: A capture write stores `cap_data` at `cap_id` in either mode. The next shadow read of that entry returns the new value.
- R11: In normal mode, reads of 08h, D0h and 20h are not claimed. `io_rd_hit` is 0 and `io_rdata` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration byte; bit 0 is the shadow enable |
| io_addr | input | 8 | I/O port address |
| io_rd | input | 1 | Read strobe, held for the length of the read |
| io_wr | input | 1 | Write strobe |
| io_rdata | output | 8 | Read data, valid while io_rd_hit is 1 |
| io_rd_hit | output | 1 | The block claims the current read |
| cap_we | input | 1 | Capture write from a peripheral core |
| cap_id | input | 6 | Copy id of the captured register |
| cap_data | input | 8 | Captured value |
| dma_cur_rdata | input | 8 | Current address or count byte from the DMA core |
| dma_base_rdata | input | 8 | Base address or count byte from the DMA core |
| dma_base_we | output | 1 | Steer the bus write into the base register |
| dma_cur_we | output | 1 | Steer the bus write into the current register |

## Verification
The hardest state to reach is a walking index in the middle of its sequence at the moment another event arrives. That event may be a read of a different port, a read held over several cycles, a write to the same port, or a toggle of the enable. The stimulus therefore walks each index partway and then interleaves those events. It reads on to confirm the expected position and checks both wrap points. The copies are loaded in normal mode and one is changed again while shadow mode is on, so the expected data ties each step to a known id.

// File: rtl/shadow_rb_pkg.sv
package shadow_rb_pkg;
  localparam int IO_AW     = 8;
  localparam int DATA_W    = 8;
  localparam int NUM_COPY  = 35;
  localparam int COPY_ID_W = $clog2(NUM_COPY + 1);
  localparam int NUM_SEQ   = 4;
  localparam int MASK_W    = 4;

  localparam logic [IO_AW-1:0] PORT_DMA_LO_MASK = 8'h0F;
  localparam logic [IO_AW-1:0] PORT_DMA_HI_MASK = 8'hDE;
  localparam logic [IO_AW-1:0] PORT_TMR_CTR0    = 8'h40;
  localparam logic [COPY_ID_W-1:0] ID_DMA_LO_MASK = 6'd12;
  localparam logic [COPY_ID_W-1:0] ID_DMA_HI_MASK = 6'd13;

  // Walking ports: address, first copy id, entry count
  function automatic logic [IO_AW-1:0] seq_port(input int g);
    case (g)
      0:       return 8'h08;
      1:       return 8'hD0;
      2:       return 8'h40;
      default: return 8'h20;
    endcase
  endfunction

  function automatic logic [COPY_ID_W-1:0] seq_base(input int g);
    case (g)
      0:       return 6'd0;
      1:       return 6'd6;
      2:       return 6'd14;
      default: return 6'd21;
    endcase
  endfunction

  function automatic int seq_len(input int g);
    case (g)
      0:       return 6;
      1:       return 6;
      2:       return 7;
      default: return 14;
    endcase
  endfunction

  // Address or count port of either DMA group
  function automatic logic is_dma_addr_cnt(input logic [IO_AW-1:0] a);
    return (a[7:3] == 5'b00000) || ((a[7:4] == 4'hC) && !a[0]);
  endfunction
endpackage

// File: rtl/shadow_cfg_reg.sv
module shadow_cfg_reg #(
  parameter int          DW        = 8,
  parameter logic [7:0]  RESET_VAL = 8'h02,
  parameter logic [7:0]  ZERO_MASK = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (we_i) q_nxt = wdata_i & ~DW'(ZERO_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= DW'(RESET_VAL);
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/shadow_copy_store.sv
module shadow_copy_store #(
  parameter int DEPTH = 35,
  parameter int DW    = 8,
  parameter int IDW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we_i,
  input  logic [IDW-1:0] wid_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [IDW-1:0] rid_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] mem_r [DEPTH];

  // Ids at or beyond DEPTH are dropped
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ent_en;
    assign ent_en = we_i && (wid_i == IDW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_r[i] <= '0;
      else if (ent_en) mem_r[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rid_i == IDW'(i)) rdata_o = mem_r[i];
  end
endmodule

// File: rtl/shadow_seq_index.sv
module shadow_seq_index #(
  parameter int LEN = 6,
  parameter int IW  = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] LAST = IW'(LEN - 1);

  logic [IW-1:0] idx_r, idx_nxt;

  always_comb begin
    idx_nxt = idx_r;
    if (clr_i)       idx_nxt = '0;
    else if (adv_i)  idx_nxt = (idx_r == LAST) ? '0 : idx_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_r <= '0;
    else        idx_r <= idx_nxt;
  end

  assign idx_o = idx_r;
endmodule

// File: rtl/shadow_readback.sv
module shadow_readback
  import shadow_rb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  input  logic [IO_AW-1:0]     io_addr,
  input  logic                 io_rd,
  input  logic                 io_wr,
  output logic [DATA_W-1:0]    io_rdata,
  output logic                 io_rd_hit,
  input  logic                 cap_we,
  input  logic [COPY_ID_W-1:0] cap_id,
  input  logic [DATA_W-1:0]    cap_data,
  input  logic [DATA_W-1:0]    dma_cur_rdata,
  input  logic [DATA_W-1:0]    dma_base_rdata,
  output logic                 dma_base_we,
  output logic                 dma_cur_we
);
  logic                 shadow_en;
  logic                 rd_q, rd_q_nxt;
  logic [IO_AW-1:0]     addr_q, addr_q_nxt;
  logic [NUM_SEQ-1:0]   seq_clr, seq_adv;
  logic [COPY_ID_W-1:0] seq_idx [NUM_SEQ];
  logic [COPY_ID_W-1:0] rd_id;
  logic [DATA_W-1:0]    copy_rdata;
  logic                 seq_sel, mask_sel, ac_sel;

  shadow_cfg_reg #(.DW(DATA_W), .RESET_VAL(8'h02), .ZERO_MASK(8'h80)) u_cfg (
    .clk, .rst_n, .we_i(cfg_we), .wdata_i(cfg_wdata), .q_o(cfg_rdata)
  );
  assign shadow_en = cfg_rdata[0];

  shadow_copy_store #(.DEPTH(NUM_COPY), .DW(DATA_W), .IDW(COPY_ID_W)) u_store (
    .clk, .rst_n, .we_i(cap_we), .wid_i(cap_id), .wdata_i(cap_data),
    .rid_i(rd_id), .rdata_o(copy_rdata)
  );

  // Read completion tracking
  always_comb begin
    rd_q_nxt   = io_rd;
    addr_q_nxt = io_rd ? io_addr : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q   <= rd_q_nxt;
      addr_q <= addr_q_nxt;
    end
  end

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
    localparam int LEN = seq_len(g);
    localparam int IW  = $clog2(LEN);
    logic [IW-1:0] idx_l;
    assign seq_clr[g] = !shadow_en || (io_wr && (io_addr == seq_port(g)));
    assign seq_adv[g] = shadow_en && rd_q && !io_rd && (addr_q == seq_port(g));
    shadow_seq_index #(.LEN(LEN), .IW(IW)) u_idx (
      .clk, .rst_n, .clr_i(seq_clr[g]), .adv_i(seq_adv[g]), .idx_o(idx_l)
    );
    assign seq_idx[g] = COPY_ID_W'(idx_l);
  end

  // Copy selection
  always_comb begin
    rd_id    = '0;
    seq_sel  = 1'b0;
    mask_sel = 1'b0;
    for (int g = 0; g < NUM_SEQ; g++) begin
      if (io_addr == seq_port(g)) begin
        seq_sel = 1'b1;
        rd_id   = seq_base(g) + seq_idx[g];
      end
    end
    if (io_addr == PORT_DMA_LO_MASK) begin
      mask_sel = 1'b1;
      rd_id    = ID_DMA_LO_MASK;
    end else if (io_addr == PORT_DMA_HI_MASK) begin
      mask_sel = 1'b1;
      rd_id    = ID_DMA_HI_MASK;
    end
  end

  assign ac_sel = is_dma_addr_cnt(io_addr);

  // Read data and claim
  always_comb begin
    io_rd_hit = 1'b0;
    io_rdata  = '0;
    if (io_rd) begin
      if (ac_sel) begin
        io_rd_hit = 1'b1;
        io_rdata  = shadow_en ? dma_base_rdata : dma_cur_rdata;
      end else if (shadow_en && seq_sel) begin
        io_rd_hit = 1'b1;
        io_rdata  = copy_rdata;
      end else if (shadow_en && mask_sel) begin
        io_rd_hit = 1'b1;
        io_rdata  = {{(DATA_W-MASK_W){1'b0}}, copy_rdata[MASK_W-1:0]};
      end else if (io_addr == PORT_TMR_CTR0) begin
        io_rd_hit = 1'b1;
      end
    end
  end

  // Write steering for address and count ports
  assign dma_base_we = io_wr && ac_sel && !shadow_en;
  assign dma_cur_we  = io_wr && ac_sel &&  shadow_en;
endmodule

// File: rtl/shadow_readback_chk.sv
module shadow_readback_chk
  import shadow_rb_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [DATA_W-1:0]    cfg_rdata,
  input logic [IO_AW-1:0]     io_addr,
  input logic                 io_rd,
  input logic                 io_wr,
  input logic [DATA_W-1:0]    io_rdata,
  input logic                 io_rd_hit,
  input logic                 cap_we,
  input logic [DATA_W-1:0]    dma_cur_rdata,
  input logic [DATA_W-1:0]    dma_base_rdata,
  input logic                 dma_base_we,
  input logic                 dma_cur_we
);
  AST_CFG_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cfg_rdata[7] == 1'b0); // R1

  AST_HELD_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && $past(io_rd) && $stable(io_addr) && !$past(io_wr) && !$past(cap_we) && !$past(cfg_we)
     && $stable(dma_cur_rdata) && $stable(dma_base_rdata)) |-> $stable(io_rdata)); // R5

  AST_STEER_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(dma_base_we && dma_cur_we)); // R8

  AST_STEER_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_base_we || dma_cur_we) |-> io_wr); // R8

  AST_BASE_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n) dma_base_we |-> !cfg_rdata[0]); // R8

  AST_MASK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[0] && io_rd && (io_addr == PORT_DMA_LO_MASK || io_addr == PORT_DMA_HI_MASK))
      |-> (io_rd_hit && io_rdata[7:4] == 4'h0)); // R9

  AST_NORMAL_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[0] && io_rd && (io_addr == 8'h08 || io_addr == 8'hD0 || io_addr == 8'h20))
      |-> (!io_rd_hit && io_rdata == '0)); // R11
endmodule

bind shadow_readback shadow_readback_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
  .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
  .io_rd_hit(io_rd_hit), .cap_we(cap_we), .dma_cur_rdata(dma_cur_rdata),
  .dma_base_rdata(dma_base_rdata), .dma_base_we(dma_base_we), .dma_cur_we(dma_cur_we)
);

// File: tb/shadow_readback_tb.sv
module shadow_readback_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [7:0] io_addr;
  logic       io_rd, io_wr;
  logic [7:0] io_rdata;
  logic       io_rd_hit;
  logic       cap_we;
  logic [5:0] cap_id;
  logic [7:0] cap_data;
  logic [7:0] dma_cur_rdata, dma_base_rdata;
  logic       dma_base_we, dma_cur_we;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic       hit;
    logic [7:0] data;
    string      tag;
  } item_t;
  item_t sb_q[$];
  event  smp;

  always #5 clk = ~clk;

  shadow_readback u_dut (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_rdata, .io_addr, .io_rd, .io_wr,
    .io_rdata, .io_rd_hit, .cap_we, .cap_id, .cap_data, .dma_cur_rdata,
    .dma_base_rdata, .dma_base_we, .dma_cur_we
  );

  function automatic logic [7:0] cp(input int id);
    return 8'h40 + 8'(id);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected item at each sample point
  initial begin
    forever begin
      @(smp);
      if (sb_q.size() == 0) begin
        chk(1'b0, "scoreboard-empty", 16'h0, 16'h0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk({io_rd_hit, io_rdata} == {it.hit, it.data}, it.tag,
            {7'h0, io_rd_hit, io_rdata}, {7'h0, it.hit, it.data});
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic hit, input logic [7:0] d, input string tag);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    sb_q.push_back('{hit, d, tag});
    @(posedge clk); #2; ->smp;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic rd_held(input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    for (int k = 0; k < 3; k++) begin
      sb_q.push_back('{1'b1, d, tag});
      @(posedge clk); #2; ->smp;
    end
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic eb, input logic ec, input string tag);
    @(negedge clk);
    io_addr = a; io_wr = 1'b1;
    @(posedge clk); #2;
    chk({dma_base_we, dma_cur_we} == {eb, ec}, tag, {14'h0, dma_base_we, dma_cur_we}, {14'h0, eb, ec});
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cap(input int id, input logic [7:0] v);
    @(negedge clk);
    cap_we = 1'b1; cap_id = 6'(id); cap_data = v;
    @(negedge clk);
    cap_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_wdata = 0; io_addr = 0; io_rd = 0; io_wr = 0;
    cap_we = 0; cap_id = 0; cap_data = 0; dma_cur_rdata = 8'h11; dma_base_rdata = 8'h22;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata == 8'h02, "R1 reset value", {8'h0, cfg_rdata}, 16'h0002);
    chk(io_rd_hit == 1'b0, "R11 idle no claim", {15'h0, io_rd_hit}, 16'h0);

    // R10: load every copy in normal mode
    for (int i = 0; i < 35; i++) cap(i, cp(i));

    rd(8'h08, 1'b0, 8'h00, "R11 normal 08h");
    rd(8'h20, 1'b0, 8'h00, "R11 normal 20h");
    rd(8'hD0, 1'b0, 8'h00, "R11 normal D0h");
    rd(8'h40, 1'b1, 8'h00, "R3 normal 40h reserved");
    rd(8'h0F, 1'b0, 8'h00, "R9 normal 0Fh");

    cfg(8'h81);
    chk(cfg_rdata == 8'h01, "R1 bit7 dropped", {8'h0, cfg_rdata}, 16'h0001);

    for (int i = 0; i < 6; i++) rd(8'h08, 1'b1, cp(i), "R2 08h walk");
    rd(8'h08, 1'b1, cp(0), "R2 08h wrap");
    for (int i = 0; i < 3; i++) rd(8'hD0, 1'b1, cp(6 + i), "R2 D0h walk");
    rd(8'h08, 1'b1, cp(1), "R5 other port no disturb");

    rd_held(8'h40, cp(14), "R5 held read");
    for (int i = 15; i <= 20; i++) rd(8'h40, 1'b1, cp(i), "R3 40h walk");
    rd(8'h40, 1'b1, cp(14), "R3 40h wrap");

    for (int i = 21; i <= 34; i++) rd(8'h20, 1'b1, cp(i), "R4 20h walk");
    rd(8'h20, 1'b1, cp(21), "R4 20h wrap");

    wr(8'h08, 1'b0, 1'b0, "R8 non-DMA-ac write");
    rd(8'h08, 1'b1, cp(0), "R6 write resets index");
    cfg(8'h00);
    cfg(8'h01);
    rd(8'hD0, 1'b1, cp(6), "R6 disable resets D0h");
    rd(8'h40, 1'b1, cp(14), "R6 disable resets 40h");

    cap(12, 8'hF5);
    rd(8'h0F, 1'b1, 8'h05, "R9 0Fh mask");
    rd(8'hDE, 1'b1, 8'h0D, "R9 DEh mask");

    rd(8'hC4, 1'b1, 8'h22, "R7 shadow reads base");
    wr(8'h02, 1'b0, 1'b1, "R8 shadow writes current");
    cfg(8'h00);
    rd(8'h04, 1'b1, 8'h11, "R7 normal reads current");
    wr(8'hCE, 1'b1, 1'b0, "R8 normal writes base");
    wr(8'hC1, 1'b0, 1'b0, "R8 odd Cxh not steered");
    rd(8'hDE, 1'b0, 8'h00, "R9 normal DEh");

    cfg(8'h01);
    wr(8'h08, 1'b0, 1'b0, "R6 reset before R10");
    cap(3, 8'h77);
    for (int i = 0; i < 3; i++) rd(8'h08, 1'b1, cp(i), "R10 walk");
    rd(8'h08, 1'b1, 8'h77, "R10 updated copy");

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) chk(1'b0, "scoreboard-leftover", 16'(sb_q.size()), 16'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule